// File: doc/BRIEF.md
# Display Host Write Interface

This block sits on the host side of a display driver and turns a stream of tagged bytes into write cycles on the driver's shared 8-bit bus. Each byte arrives on a valid/ready handshake together with two tags. One tag says whether the byte is display data or a command. The other says which of two devices receives it: the master device or the slave device. The block drives the bus, a data/command line, an active-low write strobe and one active-low select line per device.

A static mode input picks the bus format. When the mode input is high, the byte goes out as one 8-bit parallel write. The bus, the data/command line and the chip select settle one clock before the strobe falls. The strobe stays low for a parameter-set number of clocks, and everything is held for one clock after it rises. When the mode input is low, the byte is shifted out most significant bit first. Two bus pins carry the serial stream: bit 7 is the data line and bit 6 is the clock line. The chip select stays low for the whole byte.

Only one byte is in flight at a time. Ready drops at acceptance and returns once the transfer, including its hold clock, has finished.

Top module: `disp_wr_if`

## Requirements
- R1: During reset and whenever no transfer is active: wr_n=1, cs_mst_n=1, cs_slv_n=1, bus_out=8'h00 and dc_out=0. After reset is released with no transfer active, in_ready=1.
- R2: Parallel mode (par_sel=1). In the first cycle after acceptance, bus_out equals the accepted byte, the target select is low and wr_n is still high. The byte stays on the bus until the transfer ends.
- R3: Parallel mode. wr_n is low for exactly STRB_CLKS consecutive cycles, starting in the second cycle after acceptance. It is followed by one cycle with wr_n high in which the select line and the bus are still held. The next cycle is idle.
- R4: dc_out is 1 for a data byte (in_is_data=1) and 0 for a command byte. In both modes it stays constant for every cycle of the transfer.
- R5: in_to_slave=0 drives cs_mst_n low and in_to_slave=1 drives cs_slv_n low. The other select line stays high.
- R6: Serial mode (par_sel=0). bus_out[7] is the serial data and bus_out[6] is the serial clock. bus_out[5:0]=0 and wr_n=1 throughout. Bits go out MSB first, and each bit is placed while the clock is low.
- R7: Serial mode. The clock is low for SCK_HALF cycles and then high for SCK_HALF cycles for each of the 8 bits, starting in the first cycle after acceptance. One hold cycle follows, with the clock low and the select still low. The next cycle is idle.
- R8: in_ready is 0 from the cycle after acceptance until the transfer's hold cycle has ended. A byte presented while busy is not taken until in_ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_sel | input | 1 | Static bus format: 1 parallel, 0 serial |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_dat | input | 8 | Byte to write |
| in_is_data | input | 1 | 1 display data, 0 command |
| in_to_slave | input | 1 | 0 master device, 1 slave device |
| bus_out | output | 8 | Shared bus (serial: bit 7 data, bit 6 clock) |
| dc_out | output | 1 | Data/command line |
| wr_n | output | 1 | Active-low write strobe |
| cs_mst_n | output | 1 | Active-low select of the master device |
| cs_slv_n | output | 1 | Active-low select of the slave device |

## Verification
The bench builds the block with STRB_CLKS=3 and SCK_HALF=2, not the defaults of 2 and 1. This makes the strobe span several cycles and makes each serial clock phase longer than one cycle, so both down-counters must reload and count through intermediate values rather than expiring at once. Under these values a cycle-by-cycle trace of every output is compared in each mode, for both targets and both byte kinds. The same trace covers a second byte held waiting while the first is busy, and a reset that lands in the middle of a strobe.

// File: rtl/disp_wr_pkg.sv
package disp_wr_pkg;

    typedef struct packed {
        logic [7:0] dat;
        logic       is_data;
        logic       to_slave;
    } wr_item_t;

    typedef enum logic [1:0] {
        PAR_IDLE  = 2'd0,
        PAR_SETUP = 2'd1,
        PAR_STRB  = 2'd2,
        PAR_HOLD  = 2'd3
    } par_state_t;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_HOLD  = 2'd2
    } ser_state_t;

    // Serial format on the shared bus: data on bit 7, clock on bit 6.
    function automatic logic [7:0] ser_bus(input logic sdo, input logic sck);
        return {sdo, sck, 6'b000000};
    endfunction

endpackage

// File: rtl/disp_wr_par_eng.sv
module disp_wr_par_eng
    import disp_wr_pkg::*;
#(
    parameter int STRB_CLKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic strobe
);
    localparam int CW = $clog2(STRB_CLKS + 1);

    par_state_t      st;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PAR_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                PAR_IDLE:  if (go) st <= PAR_SETUP;
                PAR_SETUP: begin
                    st  <= PAR_STRB;
                    cnt <= CW'(STRB_CLKS - 1);
                end
                PAR_STRB: begin
                    if (cnt == '0) st <= PAR_HOLD;
                    else           cnt <= cnt - 1'b1;
                end
                default:   st <= PAR_IDLE;
            endcase
        end
    end

    assign busy   = (st != PAR_IDLE);
    assign strobe = (st == PAR_STRB);
endmodule

// File: rtl/disp_wr_ser_eng.sv
module disp_wr_ser_eng
    import disp_wr_pkg::*;
#(
    parameter int SCK_HALF = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] dat,
    output logic       busy,
    output logic       sck,
    output logic       sdo
);
    localparam int HW = $clog2(SCK_HALF + 1);

    ser_state_t    st;
    logic [7:0]    shreg;
    logic [2:0]    bit_idx;
    logic          phase_hi;
    logic [HW-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SER_IDLE;
            shreg    <= '0;
            bit_idx  <= '0;
            phase_hi <= 1'b0;
            hcnt     <= '0;
        end else begin
            case (st)
                SER_IDLE: if (go) begin
                    st       <= SER_SHIFT;
                    shreg    <= dat;
                    bit_idx  <= 3'd7;
                    phase_hi <= 1'b0;
                    hcnt     <= HW'(SCK_HALF - 1);
                end
                SER_SHIFT: begin
                    if (hcnt != '0) begin
                        hcnt <= hcnt - 1'b1;
                    end else begin
                        hcnt <= HW'(SCK_HALF - 1);
                        if (!phase_hi) begin
                            phase_hi <= 1'b1;
                        end else begin
                            phase_hi <= 1'b0;
                            if (bit_idx == 3'd0) begin
                                st <= SER_HOLD;
                            end else begin
                                bit_idx <= bit_idx - 1'b1;
                                shreg   <= {shreg[6:0], 1'b0};
                            end
                        end
                    end
                end
                default: st <= SER_IDLE;
            endcase
        end
    end

    assign busy = (st != SER_IDLE);
    assign sck  = (st == SER_SHIFT) && phase_hi;
    assign sdo  = shreg[7];
endmodule

// File: rtl/disp_wr_if.sv
module disp_wr_if
    import disp_wr_pkg::*;
#(
    parameter int STRB_CLKS = 2,
    parameter int SCK_HALF  = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       par_sel,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_dat,
    input  logic       in_is_data,
    input  logic       in_to_slave,
    output logic [7:0] bus_out,
    output logic       dc_out,
    output logic       wr_n,
    output logic       cs_mst_n,
    output logic       cs_slv_n
);
    wr_item_t held;
    logic     accept, p_busy, p_strobe, s_busy, s_sck, s_sdo, active;

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst)         held <= '0;
        else if (accept) held <= '{dat: in_dat, is_data: in_is_data, to_slave: in_to_slave};
    end

    disp_wr_par_eng #(.STRB_CLKS(STRB_CLKS)) par_i (
        .clk    (clk),
        .rst    (rst),
        .go     (accept && par_sel),
        .busy   (p_busy),
        .strobe (p_strobe)
    );

    disp_wr_ser_eng #(.SCK_HALF(SCK_HALF)) ser_i (
        .clk  (clk),
        .rst  (rst),
        .go   (accept && !par_sel),
        .dat  (in_dat),
        .busy (s_busy),
        .sck  (s_sck),
        .sdo  (s_sdo)
    );

    assign active   = p_busy || s_busy;
    assign in_ready = !rst && !active;
    assign wr_n     = !p_strobe;
    assign cs_mst_n = !(active && !held.to_slave);
    assign cs_slv_n = !(active && held.to_slave);
    assign dc_out   = active && held.is_data;

    always_comb begin
        if (p_busy)      bus_out = held.dat;
        else if (s_busy) bus_out = ser_bus(s_sdo, s_sck);
        else             bus_out = 8'h00;
    end
endmodule

// File: rtl/disp_wr_if_chk.sv
module disp_wr_if_chk (
    input logic       clk,
    input logic       rst,
    input logic       par_sel,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] bus_out,
    input logic       dc_out,
    input logic       wr_n,
    input logic       cs_mst_n,
    input logic       cs_slv_n
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (wr_n && cs_mst_n && cs_slv_n && bus_out == 8'h00 && !dc_out));

    p_setup_before_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && $past(wr_n) && !$past(rst)) |->
        ($past(!cs_mst_n || !cs_slv_n) && $stable(bus_out) && $stable(dc_out)));

    p_hold_after_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_n && !$past(wr_n) && !$past(rst)) |->
        ((!cs_mst_n || !cs_slv_n) && $stable(bus_out)));

    p_dc_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !$past(in_ready) && !$past(rst)) |-> $stable(dc_out));

    p_one_target_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!cs_mst_n, !cs_slv_n}));

    p_strobe_selected_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (par_sel && (!cs_mst_n || !cs_slv_n)));

    p_serial_pins_r6: assert property (@(posedge clk) disable iff (rst)
        !par_sel |-> (wr_n && bus_out[5:0] == 6'd0));

    p_sck_under_cs_r7: assert property (@(posedge clk) disable iff (rst)
        (!par_sel && bus_out[6]) |-> (!cs_mst_n || !cs_slv_n));

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
endmodule

bind disp_wr_if disp_wr_if_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .par_sel  (par_sel),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .bus_out  (bus_out),
    .dc_out   (dc_out),
    .wr_n     (wr_n),
    .cs_mst_n (cs_mst_n),
    .cs_slv_n (cs_slv_n)
);

// File: tb/disp_wr_if_tb_top.sv
module disp_wr_if_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 3;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       par_sel = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_dat = 8'h00;
    logic       in_is_data = 1'b0;
    logic       in_to_slave = 1'b0;
    logic       in_ready, dc_out, wr_n, cs_mst_n, cs_slv_n;
    logic [7:0] bus_out;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_wr_if #(.STRB_CLKS(W), .SCK_HALF(H)) dut_i (
        .clk(clk), .rst(rst), .par_sel(par_sel), .in_valid(in_valid),
        .in_ready(in_ready), .in_dat(in_dat), .in_is_data(in_is_data),
        .in_to_slave(in_to_slave), .bus_out(bus_out), .dc_out(dc_out),
        .wr_n(wr_n), .cs_mst_n(cs_mst_n), .cs_slv_n(cs_slv_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " R1 wr_n"}, wr_n, 1);
        chk({tag, " R1 cs_mst_n"}, cs_mst_n, 1);
        chk({tag, " R1 cs_slv_n"}, cs_slv_n, 1);
        chk({tag, " R1 bus"}, bus_out, 0);
        chk({tag, " R1 dc"}, dc_out, 0);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk_idle("reset");
        chk("R1 ready in reset", in_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("after reset");
        chk("R1 ready after reset", in_ready, 1);
    endtask

    // Present one byte at a negedge; it is taken at the next posedge.
    task automatic present(input logic [7:0] b, input logic d, input logic s);
        in_dat = b; in_is_data = d; in_to_slave = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_par_write(input logic [7:0] b, input logic d, input logic s);
        par_sel = 1'b1;
        present(b, d, s);
        for (int k = 1; k <= W + 3; k++) begin
            logic act = (k <= W + 2);
            chk($sformatf("R3 par wr_n k=%0d", k), wr_n, !(k >= 2 && k <= W + 1));
            chk($sformatf("R2 par bus k=%0d", k), bus_out, act ? b : 8'h00);
            chk($sformatf("R4 par dc k=%0d", k), dc_out, act && d);
            chk($sformatf("R5 par cs_mst_n k=%0d", k), cs_mst_n, !(act && !s));
            chk($sformatf("R5 par cs_slv_n k=%0d", k), cs_slv_n, !(act && s));
            chk($sformatf("R8 par ready k=%0d", k), in_ready, !act);
            @(negedge clk);
        end
    endtask

    task automatic t_ser_write(input logic [7:0] b, input logic d, input logic s);
        par_sel = 1'b0;
        present(b, d, s);
        for (int k = 1; k <= 16 * H + 2; k++) begin
            logic act = (k <= 16 * H + 1);
            if (k <= 16 * H) begin
                int  i  = (k - 1) / (2 * H);
                logic hi = ((k - 1) % (2 * H)) >= H;
                chk($sformatf("R6 ser bus k=%0d", k), bus_out, {b[7 - i], hi, 6'd0});
                chk($sformatf("R7 ser sck k=%0d", k), bus_out[6], hi);
            end else begin
                chk($sformatf("R7 ser sck/low bits k=%0d", k), bus_out[6:0], 0);
            end
            chk($sformatf("R6 ser wr_n k=%0d", k), wr_n, 1);
            chk($sformatf("R4 ser dc k=%0d", k), dc_out, act && d);
            chk($sformatf("R7 ser cs_mst_n k=%0d", k), cs_mst_n, !(act && !s));
            chk($sformatf("R7 ser cs_slv_n k=%0d", k), cs_slv_n, !(act && s));
            chk($sformatf("R8 ser ready k=%0d", k), in_ready, !act);
            @(negedge clk);
        end
    endtask

    task automatic t_back_to_back();
        par_sel = 1'b1;
        in_dat = 8'hA1; in_is_data = 1'b1; in_to_slave = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_dat = 8'h5E; in_is_data = 1'b0; in_to_slave = 1'b1;
        for (int k = 1; k <= W + 2; k++) begin
            chk($sformatf("R8 b2b ready k=%0d", k), in_ready, 0);
            chk($sformatf("R8 b2b first byte held k=%0d", k), bus_out, 8'hA1);
            chk($sformatf("R4 b2b dc k=%0d", k), dc_out, 1);
            @(negedge clk);
        end
        chk("R8 b2b ready returns", in_ready, 1);
        chk("R8 b2b idle gap bus", bus_out, 0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 b2b second byte", bus_out, 8'h5E);
        chk("R5 b2b second target", cs_slv_n, 0);
        chk("R4 b2b second dc", dc_out, 0);
        repeat (W + 2) @(negedge clk);
        chk_idle("b2b end");
    endtask

    task automatic t_reset_mid();
        par_sel = 1'b1;
        present(8'h3C, 1'b1, 1'b0);
        @(negedge clk);
        chk("R3 mid strobe low", wr_n, 0);
        rst = 1'b1;
        @(negedge clk);
        chk_idle("mid reset");
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after mid reset", in_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_par_write(8'hC5, 1'b1, 1'b0);
        t_par_write(8'h3A, 1'b0, 1'b1);
        t_ser_write(8'hB2, 1'b1, 1'b0);
        t_ser_write(8'h4D, 1'b0, 1'b1);
        t_back_to_back();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule